// File: doc/BRIEF.md
# Typed Frame Receiver with CRC Check

This block sits behind a byte-oriented serial link and turns the incoming byte stream into typed frames. A frame opens with a one-byte start code that names its kind (data, configuration or response), carries a one-byte parameter type, then a payload whose length is a multiple of four bytes, and closes with a 16-bit CRC. The link layer marks the end of each frame with a one-cycle end-of-frame strobe. Until a valid start code arrives, every byte is thrown away.

While a frame is being received, payload bytes are passed downstream one per cycle with their index. CRC bytes are never passed on. When the end strobe arrives, the block reports the frame kind, parameter type, payload length and a good/bad verdict. For data and configuration frames it asks for a positive or negative acknowledge. A good set-time data frame is also decoded into calendar fields. If the link stops in the middle of a frame, a timeout drops the partial frame and the block goes back to hunting for a start code.

Top module: `frame_rx`

## Requirements
- R1: While hunting, any byte other than the three start codes is discarded, and an end strobe has no effect: no frame result, no payload output, no abort.
- R2: Start code 0x3D marks a data frame (kind 0), 0x23 a configuration frame (kind 1) and 0x21 a response frame (kind 2). The kind is reported on `frame_kind` with the result.
- R3: The byte after the start code is the parameter type and is reported on `param_type`. Payload bytes come out on `pay_valid`/`pay_byte` in arrival order, indexed from 0. The two trailing CRC bytes are never output.
- R4: The CRC is CRC-16 with polynomial 0x1021, initial value 0xFFFF, MSB first, no reflection and no final XOR. It is computed over the start code, the type and the payload, and is received high byte first. A mismatch makes `frame_ok` low.
- R5: `frame_ok` requires the payload length to be a multiple of 4 and to equal the length expected for the type. The expected lengths are: type 0x01 → 8, 0x02 → 4, 0x03 → 12, 0x06 → 0, 0x15 → 0. Any other type always fails.
- R6: A data or configuration result raises `resp_req` together with `frame_done`, with `resp_ack` equal to `frame_ok`. A response-kind result never raises `resp_req`.
- R7: A good data frame of type 0x01 raises `time_valid` together with `frame_done`. The eight payload bytes are reserved, year offset, month, day, reserved, hour, minute, second. `time_year` is 2000 plus the offset. No other frame raises `time_valid`.
- R8: If TIMEOUT consecutive cycles pass with neither a byte nor an end strobe while a frame is open, `frame_abort` pulses TIMEOUT cycles after the last accepted byte. No result is reported and hunting resumes. A gap of TIMEOUT-1 cycles does not abort.
- R9: A frame ended with fewer than two bytes after the type, or with more than MAX_PAY payload bytes, is reported as bad. At most MAX_PAY payload bytes are output.
- R10: After reset, all pulse outputs (`frame_done`, `pay_valid`, `resp_req`, `frame_abort`, `time_valid`) are low.
- R11: All outputs are registered. `frame_done` is high in the cycle after the cycle in which the end strobe is presented, and a byte given in the same cycle as the strobe counts as the frame's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received byte is present |
| in_byte | input | 8 | Received byte |
| in_eof | input | 1 | End-of-frame strobe from the link |
| frame_done | output | 1 | One-cycle frame result pulse |
| frame_ok | output | 1 | Frame passed CRC and length checks |
| frame_kind | output | 2 | 0 data, 1 configuration, 2 response |
| param_type | output | 8 | Parameter type of the frame |
| pay_len | output | PW | Payload bytes received (saturating at MAX_PAY) |
| pay_valid | output | 1 | Payload byte strobe |
| pay_idx | output | PW | Index of the payload byte |
| pay_byte | output | 8 | Payload byte |
| resp_req | output | 1 | Request to send an acknowledge frame |
| resp_ack | output | 1 | 1 positive, 0 negative acknowledge |
| frame_abort | output | 1 | Partial frame dropped by timeout |
| time_valid | output | 1 | Decoded set-time fields are valid |
| time_year | output | 12 | Year (2000 + offset) |
| time_month | output | 8 | Month |
| time_day | output | 8 | Day |
| time_hour | output | 8 | Hour |
| time_min | output | 8 | Minute |
| time_sec | output | 8 | Second |

## Verification
The bench sweeps every non-start byte value while hunting, and sweeps all frame kinds across known and unknown types and lengths both on and off the table. A design that mixed up the expected lengths or acknowledged response frames would report wrong verdicts or stray requests. Each of the 16 CRC bits is flipped in turn, so a checker that compared only one CRC byte, or fed a CRC byte into the sum, would accept a bad frame. The timeout is probed at gaps of exactly TIMEOUT-1 and TIMEOUT cycles, where an off-by-one counter shows up as a false or missing abort. Short and oversized frames check that the held-back CRC bytes are never passed on as payload and that output stops at MAX_PAY.

// File: rtl/frx_pkg.sv
`timescale 1ns/1ps
package frx_pkg;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_CFG  = 2'd1,
        KIND_RESP = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_TYPE = 2'd1,
        ST_BODY = 2'd2
    } st_e;

    localparam logic [7:0]  SC_DATA     = 8'h3D;
    localparam logic [7:0]  SC_CFG      = 8'h23;
    localparam logic [7:0]  SC_RESP     = 8'h21;
    localparam logic [7:0]  PT_SET_TIME = 8'h01;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;
    localparam logic [15:0] CRC_POLY    = 16'h1021;

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] len;
    } len_ent_t;

    localparam int LEN_ENTRIES = 5;
    localparam len_ent_t LEN_TAB [LEN_ENTRIES] = '{
        '{code: 8'h01, len: 8'd8},
        '{code: 8'h02, len: 8'd4},
        '{code: 8'h03, len: 8'd12},
        '{code: 8'h06, len: 8'd0},
        '{code: 8'h15, len: 8'd0}
    };

    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in, input logic [7:0] b);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ b[i];
            c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return c;
    endfunction

    function automatic logic [1:0] kind_of(input logic [7:0] code);
        if (code == SC_DATA)     return KIND_DATA;
        else if (code == SC_CFG) return KIND_CFG;
        else                     return KIND_RESP;
    endfunction

endpackage

// File: rtl/frx_len_table.sv
`timescale 1ns/1ps
module frx_len_table
    import frx_pkg::*;
(
    input  logic [7:0] ptype,
    output logic       known,
    output logic [7:0] exp_len
);
    always_comb begin
        known   = 1'b0;
        exp_len = 8'd0;
        for (int e = 0; e < LEN_ENTRIES; e++) begin
            if (LEN_TAB[e].code == ptype) begin
                known   = 1'b1;
                exp_len = LEN_TAB[e].len;
            end
        end
    end
endmodule

// File: rtl/frx_timeout.sv
`timescale 1ns/1ps
module frx_timeout #(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (!active || kick) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(TIMEOUT - 1)) begin
            expire = 1'b1;
            cnt_d  = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(TIMEOUT));

    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> cnt_q == '0);
endmodule

// File: rtl/frx_time_decode.sv
`timescale 1ns/1ps
module frx_time_decode #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          emit_valid,
    input  logic [PW-1:0] emit_idx,
    input  logic [7:0]    emit_byte,
    input  logic          fin,
    input  logic          fin_set_ok,
    output logic          time_valid,
    output logic [11:0]   year,
    output logic [7:0]    month,
    output logic [7:0]    day,
    output logic [7:0]    hour,
    output logic [7:0]    minute,
    output logic [7:0]    second
);
    typedef struct packed {
        logic [7:0][7:0] stg;
        logic            tv;
        logic [11:0]     yr;
        logic [7:0]      mo;
        logic [7:0]      dy;
        logic [7:0]      hr;
        logic [7:0]      mi;
        logic [7:0]      se;
    } td_t;

    td_t d, q;

    always_comb begin
        d    = q;
        d.tv = 1'b0;
        if (emit_valid && (int'(emit_idx) < 8)) begin
            d.stg[emit_idx[2:0]] = emit_byte;
        end
        if (fin && fin_set_ok) begin
            d.tv = 1'b1;
            d.yr = 12'd2000 + {4'b0000, d.stg[1]};
            d.mo = d.stg[2];
            d.dy = d.stg[3];
            d.hr = d.stg[5];
            d.mi = d.stg[6];
            d.se = d.stg[7];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign time_valid = q.tv;
    assign year       = q.yr;
    assign month      = q.mo;
    assign day        = q.dy;
    assign hour       = q.hr;
    assign minute     = q.mi;
    assign second     = q.se;

    assert_time_from_fin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |-> $past(fin && fin_set_ok));

    assert_year_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        time_valid |-> (year >= 12'd2000));
endmodule

// File: rtl/frame_rx.sv
`timescale 1ns/1ps
module frame_rx
    import frx_pkg::*;
#(
    parameter int MAX_PAY = 16,
    parameter int TIMEOUT = 1000,
    localparam int PW     = $clog2(MAX_PAY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    input  logic          in_eof,
    output logic          frame_done,
    output logic          frame_ok,
    output logic [1:0]    frame_kind,
    output logic [7:0]    param_type,
    output logic [PW-1:0] pay_len,
    output logic          pay_valid,
    output logic [PW-1:0] pay_idx,
    output logic [7:0]    pay_byte,
    output logic          resp_req,
    output logic          resp_ack,
    output logic          frame_abort,
    output logic          time_valid,
    output logic [11:0]   time_year,
    output logic [7:0]    time_month,
    output logic [7:0]    time_day,
    output logic [7:0]    time_hour,
    output logic [7:0]    time_min,
    output logic [7:0]    time_sec
);
    typedef struct packed {
        st_e           st;
        logic [1:0]    kind;
        logic [7:0]    ptype;
        logic [15:0]   crc;
        logic [1:0]    hcnt;
        logic [7:0]    h_old;
        logic [7:0]    h_new;
        logic [PW-1:0] plen;
        logic          ovf;
        logic          done;
        logic          ok;
        logic [1:0]    o_kind;
        logic [7:0]    o_ptype;
        logic [PW-1:0] o_len;
        logic          pv;
        logic [PW-1:0] pidx;
        logic [7:0]    pbyte;
        logic          rreq;
        logic          rack;
        logic          abort;
    } rx_t;

    rx_t d, q;

    logic       tmo_expire;
    logic [7:0] lookup_type;
    logic       len_known;
    logic [7:0] len_exp;
    logic       emit_valid;
    logic       fin;
    logic       fin_set;
    logic       frame_good;

    assign lookup_type = (q.st == ST_TYPE && in_valid) ? in_byte : q.ptype;

    frx_len_table u_len (
        .ptype   (lookup_type),
        .known   (len_known),
        .exp_len (len_exp)
    );

    frx_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (q.st != ST_HUNT),
        .kick   (in_valid | in_eof),
        .expire (tmo_expire)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.rreq     = 1'b0;
        d.pv       = 1'b0;
        d.abort    = 1'b0;
        emit_valid = 1'b0;
        fin        = 1'b0;
        fin_set    = 1'b0;

        unique case (q.st)
            ST_HUNT: begin
                if (in_valid && (in_byte == SC_DATA || in_byte == SC_CFG || in_byte == SC_RESP)) begin
                    d.st   = ST_TYPE;
                    d.kind = kind_of(in_byte);
                    d.crc  = crc16_byte(CRC_SEED, in_byte);
                    d.plen = '0;
                    d.ovf  = 1'b0;
                    d.hcnt = 2'd0;
                end
            end
            ST_TYPE: begin
                if (in_valid) begin
                    d.ptype = in_byte;
                    d.crc   = crc16_byte(q.crc, in_byte);
                    d.st    = ST_BODY;
                end
            end
            ST_BODY: begin
                if (in_valid) begin
                    if (q.hcnt == 2'd2) begin
                        // oldest held byte is now known to be payload
                        d.crc = crc16_byte(q.crc, q.h_old);
                        if (q.plen == PW'(MAX_PAY)) begin
                            d.ovf = 1'b1;
                        end else begin
                            d.pv       = 1'b1;
                            d.pidx     = q.plen;
                            d.pbyte    = q.h_old;
                            d.plen     = q.plen + 1'b1;
                            emit_valid = 1'b1;
                        end
                    end else begin
                        d.hcnt = q.hcnt + 1'b1;
                    end
                    d.h_old = q.h_new;
                    d.h_new = in_byte;
                end
            end
            default: d.st = ST_HUNT;
        endcase

        frame_good = (d.st == ST_BODY) && (d.hcnt == 2'd2) && !d.ovf
                  && (d.plen[1:0] == 2'b00) && len_known
                  && (8'(d.plen) == len_exp)
                  && (d.crc == {d.h_old, d.h_new});

        if (in_eof && d.st != ST_HUNT) begin
            d.st      = ST_HUNT;
            d.done    = 1'b1;
            d.ok      = frame_good;
            d.o_kind  = d.kind;
            d.o_ptype = d.ptype;
            d.o_len   = d.plen;
            d.rreq    = (d.kind != KIND_RESP);
            d.rack    = frame_good;
            fin       = 1'b1;
            fin_set   = frame_good && (d.kind == KIND_DATA) && (d.ptype == PT_SET_TIME);
        end else if (tmo_expire) begin
            d.st    = ST_HUNT;
            d.abort = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    frx_time_decode #(.PW(PW)) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit_valid (emit_valid),
        .emit_idx   (q.plen),
        .emit_byte  (q.h_old),
        .fin        (fin),
        .fin_set_ok (fin_set),
        .time_valid (time_valid),
        .year       (time_year),
        .month      (time_month),
        .day        (time_day),
        .hour       (time_hour),
        .minute     (time_min),
        .second     (time_sec)
    );

    assign frame_done  = q.done;
    assign frame_ok    = q.ok;
    assign frame_kind  = q.o_kind;
    assign param_type  = q.o_ptype;
    assign pay_len     = q.o_len;
    assign pay_valid   = q.pv;
    assign pay_idx     = q.pidx;
    assign pay_byte    = q.pbyte;
    assign resp_req    = q.rreq;
    assign resp_ack    = q.rack;
    assign frame_abort = q.abort;

    assert_resp_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_req |-> frame_done && frame_kind != KIND_RESP);

    assert_done_abort_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && frame_abort));

    assert_ok_len4_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && frame_ok |-> pay_len[1:0] == 2'b00);

    assert_pay_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> pay_idx < PW'(MAX_PAY));

    assert_pay_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid && $past(pay_valid) && pay_idx != '0 |-> pay_idx == $past(pay_idx) + 1'b1);
endmodule

// File: tb/frame_rx_tb.sv
`timescale 1ns/1ps
module frame_rx_tb;
    localparam int MAX_PAY = 16;
    localparam int TMO     = 16;
    localparam int PW      = $clog2(MAX_PAY + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          in_eof = 1'b0;
    logic          frame_done, frame_ok, pay_valid, resp_req, resp_ack, frame_abort, time_valid;
    logic [1:0]    frame_kind;
    logic [7:0]    param_type, pay_byte, time_month, time_day, time_hour, time_min, time_sec;
    logic [PW-1:0] pay_len, pay_idx;
    logic [11:0]   time_year;

    always #2.5 clk = ~clk;

    frame_rx #(.MAX_PAY(MAX_PAY), .TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_eof(in_eof),
        .frame_done(frame_done), .frame_ok(frame_ok), .frame_kind(frame_kind),
        .param_type(param_type), .pay_len(pay_len), .pay_valid(pay_valid), .pay_idx(pay_idx),
        .pay_byte(pay_byte), .resp_req(resp_req), .resp_ack(resp_ack), .frame_abort(frame_abort),
        .time_valid(time_valid), .time_year(time_year), .time_month(time_month),
        .time_day(time_day), .time_hour(time_hour), .time_min(time_min), .time_sec(time_sec)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // monitor state (written only by the monitor)
    int       done_cnt = 0, pv_cnt = 0, abort_cnt = 0, tv_cnt = 0;
    int       done_cyc = 0, abort_cyc = 0;
    logic [7:0] mon_pay [64];
    logic       m_ok, m_rreq, m_rack;
    logic [1:0] m_kind;
    logic [7:0] m_type;
    int         m_year, m_mon, m_day, m_hr, m_min, m_sec;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (pay_valid) begin
            mon_pay[pay_idx] = pay_byte;
            pv_cnt++;
        end
        if (frame_done) begin
            done_cnt++; done_cyc = cyc;
            m_ok = frame_ok; m_rreq = resp_req; m_rack = resp_ack;
            m_kind = frame_kind; m_type = param_type;
        end
        if (frame_abort) begin abort_cnt++; abort_cyc = cyc; end
        if (time_valid) begin
            tv_cnt++;
            m_year = time_year; m_mon = time_month; m_day = time_day;
            m_hr = time_hour; m_min = time_min; m_sec = time_sec;
        end
    end

    task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference CRC, shift-register form
    function automatic logic [15:0] ref_crc(input logic [7:0] bytes [64], input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {bytes[i], 8'h00};
            for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    function automatic int ref_len(input logic [7:0] t);
        case (t)
            8'h01: return 8;
            8'h02: return 4;
            8'h03: return 12;
            8'h06: return 0;
            8'h15: return 0;
            default: return -1;
        endcase
    endfunction

    logic [7:0] fb [64];
    int         flen;
    int         last_byte_cyc = 0;
    int         eof_cyc = 0;

    task automatic build(input logic [7:0] code, input logic [7:0] pt, input int n, input int seed,
                         input logic [15:0] flip);
        logic [15:0] c;
        fb[0] = code; fb[1] = pt;
        for (int i = 0; i < n; i++) fb[2+i] = 8'((seed * 37 + i * 11 + 3) & 255);
        c = ref_crc(fb, n + 2) ^ flip;
        fb[n+2] = c[15:8];
        fb[n+3] = c[7:0];
        flen = n + 4;
    endtask

    task automatic drive(input logic v, input logic [7:0] b, input logic e);
        in_valid = v; in_byte = b; in_eof = e;
        if (v) last_byte_cyc = cyc;
        if (e) eof_cyc = cyc;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0);
    endtask

    // send fb[0..flen-1]; gap cycles inserted after byte gap_at
    task automatic send(input int gap_at, input int gap_len, input bit with_eof);
        for (int i = 0; i < flen; i++) begin
            drive(1'b1, fb[i], 1'b0);
            if (i == gap_at) idle(gap_len);
        end
        if (with_eof) drive(1'b0, 8'h00, 1'b1);
        idle(3);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d0, p0, a0, t0;
        logic [7:0] codes [3];
        logic [7:0] types [6];
        int         lens  [5];
        codes = '{8'h3D, 8'h23, 8'h21};
        types = '{8'h01, 8'h02, 8'h03, 8'h06, 8'h15, 8'h7E};
        lens  = '{0, 3, 4, 8, 12};

        @(negedge clk); @(negedge clk);
        // R10: reset state
        chk(!frame_done && !pay_valid && !resp_req && !frame_abort && !time_valid, "R10",
            "pulses low in reset", int'(frame_done | pay_valid | resp_req | frame_abort | time_valid), 0);
        rst_n = 1'b1;
        idle(2);
        chk(!frame_done && !pay_valid && !resp_req && !frame_abort && !time_valid, "R10",
            "pulses low after reset", int'(frame_done | pay_valid | resp_req | frame_abort | time_valid), 0);

        // R1: every non-start byte value is discarded while hunting
        d0 = done_cnt; p0 = pv_cnt; a0 = abort_cnt;
        for (int b = 0; b < 256; b++) begin
            if (b != 8'h3D && b != 8'h23 && b != 8'h21) drive(1'b1, 8'(b), 1'b0);
            if (b % 64 == 63) drive(1'b0, 8'h00, 1'b1);
        end
        idle(TMO + 4);
        chk(done_cnt == d0, "R1", "no result from garbage", done_cnt - d0, 0);
        chk(pv_cnt == p0, "R1", "no payload from garbage", pv_cnt - p0, 0);
        chk(abort_cnt == a0, "R1", "no abort while hunting", abort_cnt - a0, 0);

        // R7/R4/R2/R3: worked set-time example
        fb[0] = 8'h3D; fb[1] = 8'h01;
        fb[2] = 8'h00; fb[3] = 8'h08; fb[4] = 8'h0A; fb[5] = 8'h0A;
        fb[6] = 8'h00; fb[7] = 8'h11; fb[8] = 8'h14; fb[9] = 8'h00;
        begin
            logic [15:0] c;
            c = ref_crc(fb, 10);
            fb[10] = c[15:8]; fb[11] = c[7:0]; flen = 12;
        end
        d0 = done_cnt; t0 = tv_cnt;
        send(-1, 0, 1'b1);
        chk(done_cnt == d0 + 1 && m_ok, "R4", "set-time frame ok", int'(m_ok), 1);
        chk(m_kind == 2'd0, "R2", "data kind", m_kind, 0);
        chk(m_type == 8'h01, "R3", "param type", m_type, 1);
        chk(tv_cnt == t0 + 1, "R7", "time_valid pulses", tv_cnt - t0, 1);
        chk(m_year == 2008 && m_mon == 10 && m_day == 10, "R7", "date", m_year * 10000 + m_mon * 100 + m_day, 20081010);
        chk(m_hr == 17 && m_min == 20 && m_sec == 0, "R7", "clock", m_hr * 10000 + m_min * 100 + m_sec, 172000);
        chk(done_cyc == eof_cyc + 1, "R11", "done latency", done_cyc - eof_cyc, 1);

        // sweep kind x type x length
        for (int k = 0; k < 3; k++) begin
            for (int t = 0; t < 6; t++) begin
                for (int l = 0; l < 5; l++) begin
                    bit exp_ok, exp_tv, pay_match;
                    exp_ok = (lens[l] % 4 == 0) && (ref_len(types[t]) == lens[l]);
                    exp_tv = exp_ok && k == 0 && types[t] == 8'h01;
                    build(codes[k], types[t], lens[l], k * 31 + t * 7 + l, 16'h0000);
                    d0 = done_cnt; p0 = pv_cnt; t0 = tv_cnt;
                    send(-1, 0, 1'b1);
                    chk(done_cnt == d0 + 1, "R11", "one result", done_cnt - d0, 1);
                    chk(done_cyc == eof_cyc + 1, "R11", "result cycle", done_cyc - eof_cyc, 1);
                    chk(m_ok == exp_ok, "R5", "length verdict", int'(m_ok), int'(exp_ok));
                    chk(m_kind == 2'(k), "R2", "kind", m_kind, k);
                    chk(m_type == types[t], "R3", "type", m_type, types[t]);
                    chk(m_rreq == (k != 2), "R6", "response request", int'(m_rreq), int'(k != 2));
                    if (k != 2) chk(m_rack == exp_ok, "R6", "ack value", int'(m_rack), int'(exp_ok));
                    chk(pv_cnt - p0 == lens[l], "R3", "payload count", pv_cnt - p0, lens[l]);
                    pay_match = 1'b1;
                    for (int i = 0; i < lens[l]; i++) if (mon_pay[i] != fb[2+i]) pay_match = 1'b0;
                    chk(pay_match, "R3", "payload bytes", int'(pay_match), 1);
                    chk(tv_cnt - t0 == int'(exp_tv), "R7", "time pulse", tv_cnt - t0, int'(exp_tv));
                end
            end
        end

        // R4: flip every CRC bit on a valid frame
        for (int b = 0; b < 16; b++) begin
            build(8'h3D, 8'h01, 8, 100 + b, 16'(1 << b));
            d0 = done_cnt; t0 = tv_cnt;
            send(-1, 0, 1'b1);
            chk(done_cnt == d0 + 1 && !m_ok && !m_rack && m_rreq, "R4", "bad crc gives nak", int'(m_ok), 0);
            chk(tv_cnt == t0, "R7", "no time on bad crc", tv_cnt - t0, 0);
        end
        // R4: corrupted payload byte
        build(8'h23, 8'h02, 4, 55, 16'h0000);
        fb[3] = fb[3] ^ 8'h40;
        d0 = done_cnt;
        send(-1, 0, 1'b1);
        chk(done_cnt == d0 + 1 && !m_ok, "R4", "payload corruption", int'(m_ok), 0);

        // R9: short frames
        d0 = done_cnt;
        drive(1'b1, 8'h3D, 1'b0); drive(1'b1, 8'h06, 1'b0); drive(1'b1, 8'hAA, 1'b0);
        drive(1'b0, 8'h00, 1'b1); idle(3);
        chk(done_cnt == d0 + 1 && !m_ok && m_rreq, "R9", "one byte after type", int'(m_ok), 0);
        d0 = done_cnt;
        drive(1'b1, 8'h23, 1'b1); idle(3);
        chk(done_cnt == d0 + 1 && !m_ok, "R9", "start code with end strobe", int'(m_ok), 0);

        // R9: oversize payload
        build(8'h3D, 8'h01, MAX_PAY + 4, 9, 16'h0000);
        d0 = done_cnt; p0 = pv_cnt;
        send(-1, 0, 1'b1);
        chk(done_cnt == d0 + 1 && !m_ok, "R9", "oversize nak", int'(m_ok), 0);
        chk(pv_cnt - p0 == MAX_PAY, "R9", "payload capped", pv_cnt - p0, MAX_PAY);

        // R11: end strobe together with last byte
        build(8'h21, 8'h02, 4, 77, 16'h0000);
        d0 = done_cnt;
        for (int i = 0; i < flen - 1; i++) drive(1'b1, fb[i], 1'b0);
        drive(1'b1, fb[flen-1], 1'b1);
        idle(3);
        chk(done_cnt == d0 + 1 && m_ok && !m_rreq, "R11", "last byte with strobe", int'(m_ok), 1);

        // R8: gap of TMO-1 survives, gap of TMO aborts
        build(8'h3D, 8'h02, 4, 5, 16'h0000);
        d0 = done_cnt; a0 = abort_cnt;
        send(3, TMO - 1, 1'b1);
        chk(done_cnt == d0 + 1 && m_ok, "R8", "gap below limit kept", int'(m_ok), 1);
        chk(abort_cnt == a0, "R8", "no abort below limit", abort_cnt - a0, 0);
        d0 = done_cnt; a0 = abort_cnt;
        for (int i = 0; i < 4; i++) drive(1'b1, fb[i], 1'b0);
        idle(TMO + 3);
        drive(1'b0, 8'h00, 1'b1); idle(3);
        chk(abort_cnt == a0 + 1, "R8", "abort at limit", abort_cnt - a0, 1);
        chk(abort_cyc == last_byte_cyc + 1 + TMO, "R8", "abort timing", abort_cyc - last_byte_cyc - 1, TMO);
        chk(done_cnt == d0, "R8", "no result after abort", done_cnt - d0, 0);
        send(-1, 0, 1'b1);
        chk(done_cnt == d0 + 1 && m_ok, "R8", "hunting resumes", int'(m_ok), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule